// File: doc/BRIEF.md
# Interrupt Controller Command Word Interface

This block is the processor-facing programming front end of an eight-line interrupt controller. It has a byte-wide port with one address bit. Writes on that port either step the controller through its multi-byte initialization sequence or act as run-time operation commands. The same address can reach different registers. Offset 1 is the mask register when no initialization is in progress. During initialization it is whichever initialization byte comes next.

The block keeps the configuration that results: the interrupt mask, the vector base, the cascade map or slave identity, the trigger mode, the single or cascaded arrangement, the automatic end-of-interrupt flag, and the choice of pending or in-service register for reads. End-of-interrupt commands reach the priority core as a one-cycle strobe with a line number. The pending and in-service vectors come from that core and are only read here. Arbitration is done elsewhere. Commands for rotation, special mask and buffering are accepted and change nothing.

Top module: `pic_cmd_regs`

## Requirements
- R1: After synchronous reset, all of the following hold. The mask, vector base, cascade map, trigger mode, cascade flag and automatic end-of-interrupt flag are 0. `eoi_valid` is low and `bus_rdata` is 0. The sequence is idle. Reads at offset 0 return the pending vector.
- R2: A write to offset 0 with bit 4 = 1 starts initialization, even in the middle of a sequence. It clears the mask. It sets the trigger mode to bit 3 (1 = edge), and the cascade flag to the inverse of bit 1. Bit 0 = 1 means a final configuration byte will follow. When bit 0 = 0, automatic end-of-interrupt is cleared. The next offset-1 write is the vector byte.
- R3: The vector byte sets the vector base to the written byte with bits 2:0 forced to 0. When cascaded, the next offset-1 write is the cascade byte. Otherwise the cascade map becomes 0 and the sequence goes idle.
- R4: The cascade byte is stored whole when `cfg_master` = 1. When `cfg_master` = 0 only bits 2:0 are kept and the upper bits read as 0. The sequence then expects the final byte if one was announced, and otherwise goes idle.
- R5: The final configuration byte sets automatic end-of-interrupt to its bit 1 and returns the sequence to idle.
- R6: An offset-1 write while idle loads the mask register with the written byte.
- R7: An offset-0 write with bits 4:3 = 00 and bits 7:5 = 001 gives a nonspecific end-of-interrupt. In the cycle after the write, `eoi_valid` is high for exactly one cycle and `eoi_line` is the highest set bit of `isr_in` sampled at the write. No strobe is given if `isr_in` is 0.
- R8: An offset-0 write with bits 4:3 = 00 and bits 7:5 = 011 gives a strobe in the next cycle with `eoi_line` = bits 2:0 of the written byte.
- R9: Offset-0 writes with bits 4:3 = 00 and any other value of bits 7:5 give no strobe and change no state. So do the special-mask bits (7:6) of a read-select command.
- R10: An offset-0 write with bits 4:3 = 01 and bit 1 = 1 sets the read select to bit 0 (1 = pending, 0 = in-service). With bit 1 = 0 the read select is unchanged. Offset-0 command writes never advance the initialization sequence.
- R11: A read is registered. One cycle after `bus_rd`, `bus_rdata` holds the mask for offset 1, or the selected vector for offset 0. It keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| bus_addr | input | 1 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irr_in | input | NL | Pending vector from priority core |
| isr_in | input | NL | In-service vector from priority core |
| mask_out | output | NL | Interrupt mask |
| vec_base | output | DW | Vector base, low bits zero |
| casc_map | output | DW | Slave map (master) or slave identity |
| edge_trig | output | 1 | 1 = edge triggered |
| cascade_en | output | 1 | 1 = cascaded arrangement |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_line | output | clog2(NL) | Line to retire |

## Verification
The assertions check on every cycle several properties that follow from a single write. A start write leaves the mask at zero and, without a final byte, automatic end-of-interrupt off. An idle data write lands in the mask. The vector byte always moves the sequence on. A slave cascade byte never leaves upper bits set. Every strobe can be traced to an earlier end-of-interrupt command, and the no-op command codes never produce one.

Some behaviours only the bench scenarios can show. These are the routing of offset-1 bytes through the whole sequence for each combination of cascade and final-byte flags, including restarts partway through. They also include the nonspecific line choice against live in-service patterns, and the read select across later command writes.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_VEC   = 2'd1,
    SEQ_CASC  = 2'd2,
    SEQ_FINAL = 2'd3
  } seq_t;

  localparam logic [2:0] CMD_EOI_ANY  = 3'b001;
  localparam logic [2:0] CMD_EOI_LINE = 3'b011;
  localparam logic [1:0] SUB_EOI      = 2'b00;
  localparam logic [1:0] SUB_RDSEL    = 2'b01;
endpackage

// File: rtl/pic_msb_find.sv
module pic_msb_find #(
  parameter int W  = 8,
  localparam int LW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [LW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = i[LW-1:0];
    end
  end
  assign found = |vec;
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_master,
  input  logic          start_wr,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  output logic          seq_idle,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] casc_map,
  output logic          edge_trig,
  output logic          cascade_en,
  output logic          auto_eoi
);
  seq_t          state;
  logic          need_final;
  logic [DW-1:0] vec_n;
  logic [DW-1:0] map_n;

  always_comb begin
    vec_n = wdata;
    vec_n[LW-1:0] = '0;
    if (cfg_master) begin
      map_n = wdata;
    end else begin
      map_n = '0;
      map_n[LW-1:0] = wdata[LW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      need_final <= 1'b0;
      vec_base   <= '0;
      casc_map   <= '0;
      edge_trig  <= 1'b0;
      cascade_en <= 1'b0;
      auto_eoi   <= 1'b0;
    end else if (start_wr) begin
      edge_trig  <= wdata[3];
      cascade_en <= ~wdata[1];
      need_final <= wdata[0];
      if (!wdata[0]) auto_eoi <= 1'b0;
      state <= SEQ_VEC;
    end else if (dat_wr) begin
      case (state)
        SEQ_VEC: begin
          vec_base <= vec_n;
          if (cascade_en) begin
            state <= SEQ_CASC;
          end else begin
            casc_map <= '0;
            state    <= SEQ_IDLE;
          end
        end
        SEQ_CASC: begin
          casc_map <= map_n;
          state    <= need_final ? SEQ_FINAL : SEQ_IDLE;
        end
        SEQ_FINAL: begin
          auto_eoi <= wdata[1];
          state    <= SEQ_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign seq_idle = (state == SEQ_IDLE);

  assert_vec_leaves_R3: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_VEC && dat_wr && !start_wr) |=> (state != SEQ_VEC));

  assert_slave_id_R4: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_CASC && dat_wr && !start_wr && !cfg_master) |=> (casc_map[DW-1:LW] == '0));

  assert_start_aeoi_R2: assert property (@(posedge clk) disable iff (rst)
    (start_wr && !wdata[0]) |=> !auto_eoi);
endmodule

// File: rtl/pic_ocw_decode.sv
module pic_ocw_decode
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter int NL = 8,
  localparam int LW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  input  logic [NL-1:0] isr_in,
  output logic          eoi_valid,
  output logic [LW-1:0] eoi_line,
  output logic          rd_pend_sel
);
  logic          is_eoi_cmd;
  logic          is_rdsel_cmd;
  logic          isr_any;
  logic [LW-1:0] isr_top;

  pic_msb_find #(.W(NL)) u_top (
    .vec   (isr_in),
    .found (isr_any),
    .idx   (isr_top)
  );

  always_comb begin
    is_eoi_cmd   = cmd_wr && (wdata[4:3] == SUB_EOI);
    is_rdsel_cmd = cmd_wr && (wdata[4:3] == SUB_RDSEL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eoi_valid   <= 1'b0;
      eoi_line    <= '0;
      rd_pend_sel <= 1'b1;
    end else begin
      eoi_valid <= 1'b0;
      if (is_eoi_cmd) begin
        case (wdata[7:5])
          CMD_EOI_ANY: begin
            if (isr_any) begin
              eoi_valid <= 1'b1;
              eoi_line  <= isr_top;
            end
          end
          CMD_EOI_LINE: begin
            eoi_valid <= 1'b1;
            eoi_line  <= wdata[LW-1:0];
          end
          default: ;
        endcase
      end
      if (is_rdsel_cmd && wdata[1]) rd_pend_sel <= wdata[0];
    end
  end

  assert_eoi_cause_R7: assert property (@(posedge clk) disable iff (rst)
    eoi_valid |-> $past(cmd_wr && (wdata[4:3] == SUB_EOI)));

  assert_noop_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (is_eoi_cmd && wdata[7:5] != CMD_EOI_ANY && wdata[7:5] != CMD_EOI_LINE) |=> !eoi_valid);
endmodule

// File: rtl/pic_cmd_regs.sv
module pic_cmd_regs #(
  parameter int DW = 8,
  parameter int NL = 8,
  localparam int LW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_master,
  input  logic          bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NL-1:0] irr_in,
  input  logic [NL-1:0] isr_in,
  output logic [NL-1:0] mask_out,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] casc_map,
  output logic          edge_trig,
  output logic          cascade_en,
  output logic          auto_eoi,
  output logic          eoi_valid,
  output logic [LW-1:0] eoi_line
);
  logic          wr_cmd;
  logic          wr_dat;
  logic          start_wr;
  logic          seq_idle;
  logic          rd_pend_sel;
  logic [DW-1:0] rd_next;

  assign wr_cmd   = bus_wr && !bus_addr;
  assign wr_dat   = bus_wr && bus_addr;
  assign start_wr = wr_cmd && bus_wdata[4];

  pic_init_seq #(.DW(DW), .LW(LW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cfg_master (cfg_master),
    .start_wr   (start_wr),
    .dat_wr     (wr_dat),
    .wdata      (bus_wdata),
    .seq_idle   (seq_idle),
    .vec_base   (vec_base),
    .casc_map   (casc_map),
    .edge_trig  (edge_trig),
    .cascade_en (cascade_en),
    .auto_eoi   (auto_eoi)
  );

  pic_ocw_decode #(.DW(DW), .NL(NL)) u_ocw (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr      (wr_cmd && !bus_wdata[4]),
    .wdata       (bus_wdata),
    .isr_in      (isr_in),
    .eoi_valid   (eoi_valid),
    .eoi_line    (eoi_line),
    .rd_pend_sel (rd_pend_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_out <= '0;
    end else if (start_wr) begin
      mask_out <= '0;
    end else if (wr_dat && seq_idle) begin
      mask_out <= bus_wdata[NL-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr) rd_next[NL-1:0] = mask_out;
    else          rd_next[NL-1:0] = rd_pend_sel ? irr_in : isr_in;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assert_start_clears_mask_R2: assert property (@(posedge clk) disable iff (rst)
    start_wr |=> (mask_out == '0));

  assert_idle_mask_load_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_dat && seq_idle) |=> (mask_out == $past(bus_wdata[NL-1:0])));
endmodule

// File: tb/pic_cmd_regs_tb.sv
module pic_cmd_regs_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_master = 1'b1;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irr_in = '0;
  logic [7:0] isr_in = '0;
  logic [7:0] mask_out, vec_base, casc_map;
  logic       edge_trig, cascade_en, auto_eoi, eoi_valid;
  logic [2:0] eoi_line;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_mask, m_vec, m_map;
  logic       m_edge, m_casc, m_need4, m_aeoi, m_pend;
  int         m_st;
  logic       x_ev;
  logic [2:0] x_el;

  always #2.5 clk = ~clk;

  pic_cmd_regs u_dut (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irr_in(irr_in), .isr_in(isr_in), .mask_out(mask_out), .vec_base(vec_base),
    .casc_map(casc_map), .edge_trig(edge_trig), .cascade_en(cascade_en),
    .auto_eoi(auto_eoi), .eoi_valid(eoi_valid), .eoi_line(eoi_line)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] top_bit(input logic [7:0] v);
    logic [2:0] r = 3'd0;
    for (int i = 0; i < 8; i++) if (v[i]) r = i[2:0];
    return r;
  endfunction

  task automatic model_reset();
    m_mask = 0; m_vec = 0; m_map = 0; m_edge = 0; m_casc = 0;
    m_need4 = 0; m_aeoi = 0; m_pend = 1; m_st = 0;
  endtask

  task automatic model_write(input logic a, input logic [7:0] d);
    x_ev = 0; x_el = 0;
    if (!a) begin
      if (d[4]) begin
        m_mask = 0; m_edge = d[3]; m_casc = ~d[1]; m_need4 = d[0];
        if (!d[0]) m_aeoi = 0;
        m_st = 1;
      end else if (d[4:3] == 2'b00) begin
        if (d[7:5] == 3'b001 && isr_in != 0) begin x_ev = 1; x_el = top_bit(isr_in); end
        if (d[7:5] == 3'b011) begin x_ev = 1; x_el = d[2:0]; end
      end else if (d[1]) begin
        m_pend = d[0];
      end
    end else begin
      case (m_st)
        0: m_mask = d;
        1: begin
          m_vec = d & 8'hF8;
          if (m_casc) m_st = 2;
          else begin m_map = 0; m_st = 0; end
        end
        2: begin
          m_map = cfg_master ? d : (d & 8'h07);
          m_st = m_need4 ? 3 : 0;
        end
        default: begin m_aeoi = d[1]; m_st = 0; end
      endcase
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " mask R2/R6"}, mask_out, m_mask);
    chk({tag, " vec R3"}, vec_base, m_vec);
    chk({tag, " map R4"}, casc_map, m_map);
    chk({tag, " edge R2"}, edge_trig, m_edge);
    chk({tag, " cascade R2"}, cascade_en, m_casc);
    chk({tag, " aeoi R5"}, auto_eoi, m_aeoi);
    chk({tag, " eoi_valid R7/R8/R9"}, eoi_valid, x_ev);
    if (x_ev) chk({tag, " eoi_line R7/R8"}, eoi_line, x_el);
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    model_write(a, d);
    @(negedge clk);
    bus_wr = 0;
    check_state(tag);
  endtask

  task automatic rd(input logic a, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    exp = a ? m_mask : (m_pend ? irr_in : isr_in);
    @(negedge clk);
    bus_rd = 0;
    chk({tag, " rdata R11"}, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] keep;
    void'($urandom(32'h5EED1234));
    model_reset();
    x_ev = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_state("reset R1");
    chk("reset rdata R1", bus_rdata, 0);
    irr_in = 8'h96; isr_in = 8'h21;
    rd(0, "reset select R1");
    rd(1, "reset mask R1");

    // master, cascaded, final byte expected
    wr(1, 8'h3C, "idle mask R6");
    wr(0, 8'h19, "start R2");
    wr(1, 8'h2D, "vector R3");
    wr(1, 8'hA4, "master map R4");
    wr(1, 8'h03, "final aeoi R5");
    wr(1, 8'h5A, "mask after init R6");
    rd(1, "mask read R11");

    // single, no final byte: aeoi cleared, map zeroed
    wr(0, 8'h12, "start no final R2");
    wr(1, 8'h47, "vector single R3");
    wr(1, 8'hC3, "mask after single R6");

    // slave identity
    cfg_master = 0;
    wr(0, 8'h11, "start slave R2");
    wr(1, 8'h80, "vector slave R3");
    wr(1, 8'hFE, "slave id R4");
    wr(1, 8'h02, "slave final R5");
    cfg_master = 1;

    // cascaded without final byte
    wr(0, 8'h10, "start casc R2");
    wr(1, 8'h08, "vector casc R3");
    wr(1, 8'h0F, "map then idle R4");
    wr(1, 8'h77, "mask after casc R6");

    // restart mid-sequence
    wr(0, 8'h1B, "start A R2");
    wr(0, 8'h18, "restart R2");
    wr(1, 8'hF1, "vector after restart R3");

    // end-of-interrupt commands
    isr_in = 8'h28;
    wr(0, 8'h20, "nonspecific R7");
    @(negedge clk);
    chk("strobe one cycle R7", eoi_valid, 0);
    isr_in = 8'h00;
    wr(0, 8'h20, "nonspecific empty R7");
    isr_in = 8'h81;
    wr(0, 8'h63, "specific R8");
    wr(0, 8'h65, "specific R8");
    foreach (keep[i]) keep[i] = 1'b0;
    wr(0, 8'h00, "noop 000 R9");
    wr(0, 8'h47, "noop 010 R9");
    wr(0, 8'h82, "noop 100 R9");
    wr(0, 8'hA1, "noop 101 R9");
    wr(0, 8'hC5, "noop 110 R9");
    wr(0, 8'hE7, "noop 111 R9");
    irr_in = 8'h5A; isr_in = 8'hA5;
    wr(0, 8'hC8, "special mask bits R9/R10");
    rd(0, "select kept R10");
    wr(0, 8'h0A, "select isr R10");
    rd(0, "isr read R10");
    wr(0, 8'h09, "bit1 clear R10");
    rd(0, "select unchanged R10");
    wr(0, 8'h0B, "select irr R10");
    rd(0, "irr read R10");
    wr(1, 8'h33, "commands keep idle R10");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [7:0] d;
      r = $urandom_range(0, 9);
      d = 8'($urandom);
      irr_in = 8'($urandom);
      isr_in = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      if ($urandom_range(0, 7) == 0) cfg_master = ~cfg_master;
      case (r)
        0:       wr(0, d | 8'h10, "rand start R2");
        1, 2, 3: wr(1, d, "rand data R3/R4/R5/R6");
        4, 5:    wr(0, {d[7:5], 2'b00, d[2:0]}, "rand eoi R7/R8/R9");
        6:       wr(0, {d[7:5], 2'b01, d[2:0]}, "rand select R10");
        default: rd(d[0], "rand read R11");
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule